// File: doc/BRIEF.md
# Scaled Correlation Image Reconstructor

This block rebuilds an image from a single-detector measurement sequence. A capture stage fills a buffer with N detector readings, one per projected binary mask, and then pulses a frame-complete strobe. The block sweeps every mask once per strip of pixels and, for each pixel, forms a weighted correlation in fixed point: a per-mask weight α and its square α² scale each reading. It then combines the result with two terms that depend only on the masks, one global constant and one per-pixel value, both held in read-only tables outside the block. Every term that involves no detector reading is precomputed. The hardware therefore accumulates only the reading-dependent sums: one scalar sum of α·S, and one sum of α²·S per pixel lane.

The pixels are handled LANES at a time. For each strip the block steps the mask index from 0 to N-1, one per clock. The sample buffer, the weight table, the mask table and the per-pixel table each return data one cycle after their address. After the sweep the block hands the strip's results to the host port, one pixel per accepted beat. The 1/N averages are right shifts by log2(N), so N, LANES and the pixel count are powers of two. A done flag marks the point where the last result of the frame has been taken.

Top module: `scr_recon`

## Requirements
- R1: Each result equals sat(A·(ΣS·α²·m >> log2 N) − (ΣS·α >> log2 N)·B). The sums run over all N masks, m is that pixel's mask bit, A is `a_coef` and B is that pixel's table value. The products and shifts are unsigned integers.
- R2: A mask bit of 0 leaves the pixel's correlation sum unchanged. With every mask bit of a pixel at 0, the result is −(ΣS·α >> log2 N)·B.
- R3: The scalar term ΣS·α covers all N masks of the frame and is the same for every strip of that frame.
- R4: A result above 2^(OW−1)−1 is clamped to that value. A result below −2^(OW−1) is clamped to −2^(OW−1).
- R5: Results leave in ascending pixel order, and pixel = strip·LANES + lane. Bit l of `mask_bits` is lane l, and bits [l·BW +: BW] of `b_coef` are lane l's table value.
- R6: When `frame_done` is sampled with the block idle or done, `res_valid` rises exactly N+1 cycles later. The same N+1 cycles separate the last beat of a strip from the first beat of the next strip.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_pixel` hold.
- R8: `done` rises in the cycle after the frame's final accepted beat. It stays high until `frame_done` is sampled again, and it clears in the cycle after that. `done` and `res_valid` are never high together.
- R9: A `frame_done` pulse while a frame is being computed or drained has no effect: no extra results appear and `done` stays high afterwards.
- R10: During reset `res_valid` and `done` are low.
- R11: `pat_idx` sweeps 0 to N−1 advancing by one each cycle and otherwise rests at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | Capture buffer full; starts a frame |
| pat_idx | output | log2(NPAT) | Mask index for the sample buffer, weight table and mask table |
| strip_idx | output | log2(PIX/LANES) | Strip address for the mask table and per-pixel table |
| samp_data | input | SW | Detector reading for `pat_idx`, one cycle late |
| alpha | input | AW | Weight α for `pat_idx`, one cycle late |
| alpha_sq | input | ASQW | Weight α² for `pat_idx`, one cycle late |
| mask_bits | input | LANES | Mask bits of the strip's lanes for `pat_idx`, one cycle late |
| b_coef | input | LANES*BW | Per-pixel table values of the strip, one cycle late |
| a_coef | input | ACW | Global mask-derived constant A |
| res_valid | output | 1 | Result beat available |
| res_ready | input | 1 | Host accepts the beat |
| res_pixel | output | log2(PIX) | Pixel index of the beat |
| res_data | output | OW | Signed saturated result |
| done | output | 1 | Frame fully drained |

## Verification
The first beat of a frame is due exactly N+1 cycles after the edge that samples `frame_done`. The bench checks that `res_valid` is still low after N edges and high after N+1. Each later beat is compared against a queue of expected pixel and value pairs when the handshake is seen. The monitor samples on the falling edge, and the bench changes `res_ready` just after the rising edge, so a visible handshake is exactly the one the design takes. `done` is checked one edge after the last expected item leaves the queue. A start pulsed mid-frame is checked by watching for stray beats and for `done` dropping over the following 3N cycles.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int DEF_NPAT  = 16;
    localparam int DEF_PIX   = 32;
    localparam int DEF_LANES = 8;
    localparam int DEF_SW    = 12;
    localparam int DEF_AW    = 8;
    localparam int DEF_ASQW  = 16;
    localparam int DEF_ACW   = 16;
    localparam int DEF_BW    = 20;
    localparam int DEF_OW    = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWEEP,
        ST_DRAIN,
        ST_EMIT,
        ST_FIN
    } seq_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/scr_seq.sv
module scr_seq
    import scr_pkg::*;
#(
    parameter int NPAT   = DEF_NPAT,
    parameter int STRIPS = DEF_PIX / DEF_LANES,
    parameter int LANES  = DEF_LANES,
    localparam int PW    = idx_w(NPAT),
    localparam int STW   = idx_w(STRIPS),
    localparam int LNW   = idx_w(LANES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           out_ready,
    output logic [PW-1:0]  pat_idx,
    output logic [STW-1:0] strip_idx,
    output logic [LNW-1:0] lane_sel,
    output logic           data_vld,
    output logic           clr_lanes,
    output logic           clr_scalar,
    output logic           out_valid,
    output logic           done
);

    seq_state_e     state;
    logic [PW-1:0]  k_q;
    logic [STW-1:0] strip_q;
    logic [LNW-1:0] lane_q;
    logic           vld_q;
    logic           accept;
    logic           lane_last;
    logic           strip_last;

    assign accept     = ((state == ST_IDLE) || (state == ST_FIN)) && start;
    assign lane_last  = (lane_q == LNW'(LANES - 1));
    assign strip_last = (strip_q == STW'(STRIPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            k_q     <= '0;
            strip_q <= '0;
            lane_q  <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= (state == ST_SWEEP);
            case (state)
                ST_IDLE, ST_FIN: begin
                    if (start) begin
                        state   <= ST_SWEEP;
                        k_q     <= '0;
                        strip_q <= '0;
                        lane_q  <= '0;
                    end
                end
                ST_SWEEP: begin
                    if (k_q == PW'(NPAT - 1)) begin
                        k_q   <= '0;
                        state <= ST_DRAIN;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    state <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (lane_last) begin
                            lane_q <= '0;
                            if (strip_last) begin
                                state <= ST_FIN;
                            end else begin
                                strip_q <= strip_q + 1'b1;
                                state   <= ST_SWEEP;
                            end
                        end else begin
                            lane_q <= lane_q + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign clr_scalar = accept;
    assign clr_lanes  = accept ||
                        ((state == ST_EMIT) && out_ready && lane_last && !strip_last);
    assign pat_idx    = k_q;
    assign strip_idx  = strip_q;
    assign lane_sel   = lane_q;
    assign data_vld   = vld_q;
    assign out_valid  = (state == ST_EMIT);
    assign done       = (state == ST_FIN);

endmodule

// File: rtl/scr_scalar.sv
module scr_scalar #(
    parameter int SPW   = 20,
    parameter int LOGN  = 4,
    localparam int SACW = SPW + LOGN
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           en,
    input  logic [SPW-1:0] prod,
    output logic [SPW-1:0] mean
);

    logic [SACW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_q + SACW'(prod);
        end
    end

    assign mean = SPW'(acc_q >> LOGN);

endmodule

// File: rtl/scr_lane.sv
module scr_lane
    import scr_pkg::*;
#(
    parameter int PROD_W = 28,
    parameter int LOGN   = 4,
    parameter int ACW    = 16,
    parameter int SMW    = 20,
    parameter int BW     = 20,
    parameter int OW     = 24,
    localparam int ACC_W  = PROD_W + LOGN,
    localparam int FULL_W = max2(ACW + PROD_W, SMW + BW) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 hit,
    input  logic [PROD_W-1:0]    prod,
    input  logic [ACW-1:0]       a_coef,
    input  logic [SMW-1:0]       smean,
    input  logic [BW-1:0]        b_val,
    output logic signed [OW-1:0] res
);

    localparam logic signed [FULL_W-1:0] HI = FULL_W'((64'sd1 <<< (OW - 1)) - 64'sd1);
    localparam logic signed [FULL_W-1:0] LO = -HI - FULL_W'(1);

    logic [ACC_W-1:0]         acc_q;
    logic [PROD_W-1:0]        c_mean;
    logic [FULL_W-1:0]        term_a;
    logic [FULL_W-1:0]        term_b;
    logic signed [FULL_W-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (en && hit) begin
            acc_q <= acc_q + ACC_W'(prod);
        end
    end

    always_comb begin
        c_mean = PROD_W'(acc_q >> LOGN);
        term_a = FULL_W'(a_coef) * FULL_W'(c_mean);
        term_b = FULL_W'(smean) * FULL_W'(b_val);
        diff   = $signed(term_a) - $signed(term_b);
        if (diff > HI) begin
            res = OW'(HI);
        end else if (diff < LO) begin
            res = OW'(LO);
        end else begin
            res = OW'(diff);
        end
    end

endmodule

// File: rtl/scr_recon.sv
module scr_recon
    import scr_pkg::*;
#(
    parameter int NPAT  = DEF_NPAT,
    parameter int PIX   = DEF_PIX,
    parameter int LANES = DEF_LANES,
    parameter int SW    = DEF_SW,
    parameter int AW    = DEF_AW,
    parameter int ASQW  = DEF_ASQW,
    parameter int ACW   = DEF_ACW,
    parameter int BW    = DEF_BW,
    parameter int OW    = DEF_OW,
    localparam int LOGN   = idx_w(NPAT),
    localparam int STRIPS = PIX / LANES,
    localparam int STW    = idx_w(STRIPS),
    localparam int LNW    = idx_w(LANES),
    localparam int PXW    = STW + LNW,
    localparam int PROD_W = SW + ASQW,
    localparam int SPW    = SW + AW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  frame_done,
    output logic [LOGN-1:0]       pat_idx,
    output logic [STW-1:0]        strip_idx,
    input  logic [SW-1:0]         samp_data,
    input  logic [AW-1:0]         alpha,
    input  logic [ASQW-1:0]       alpha_sq,
    input  logic [LANES-1:0]      mask_bits,
    input  logic [LANES*BW-1:0]   b_coef,
    input  logic [ACW-1:0]        a_coef,
    output logic                  res_valid,
    input  logic                  res_ready,
    output logic [PXW-1:0]        res_pixel,
    output logic signed [OW-1:0]  res_data,
    output logic                  done
);

    logic [LNW-1:0]        lane_sel;
    logic                  data_vld;
    logic                  clr_lanes;
    logic                  clr_scalar;
    logic [PROD_W-1:0]     px_prod;
    logic [SPW-1:0]        sc_prod;
    logic [SPW-1:0]        sc_mean;
    logic                  sc_en;
    logic signed [OW-1:0]  lane_res [LANES];

    scr_seq #(
        .NPAT   (NPAT),
        .STRIPS (STRIPS),
        .LANES  (LANES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (frame_done),
        .out_ready  (res_ready),
        .pat_idx    (pat_idx),
        .strip_idx  (strip_idx),
        .lane_sel   (lane_sel),
        .data_vld   (data_vld),
        .clr_lanes  (clr_lanes),
        .clr_scalar (clr_scalar),
        .out_valid  (res_valid),
        .done       (done)
    );

    assign px_prod = PROD_W'(samp_data) * PROD_W'(alpha_sq);
    assign sc_prod = SPW'(samp_data) * SPW'(alpha);
    assign sc_en   = data_vld && (strip_idx == '0);

    scr_scalar #(
        .SPW  (SPW),
        .LOGN (LOGN)
    ) u_scalar (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_scalar),
        .en   (sc_en),
        .prod (sc_prod),
        .mean (sc_mean)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        scr_lane #(
            .PROD_W (PROD_W),
            .LOGN   (LOGN),
            .ACW    (ACW),
            .SMW    (SPW),
            .BW     (BW),
            .OW     (OW)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr_lanes),
            .en     (data_vld),
            .hit    (mask_bits[l]),
            .prod   (px_prod),
            .a_coef (a_coef),
            .smean  (sc_mean),
            .b_val  (b_coef[l*BW +: BW]),
            .res    (lane_res[l])
        );
    end

    assign res_data  = lane_res[lane_sel];
    assign res_pixel = {strip_idx, lane_sel};

endmodule

// File: rtl/scr_recon_chk.sv
module scr_recon_chk #(
    parameter int LOGN = 4,
    parameter int STW  = 2,
    parameter int PXW  = 5,
    parameter int OW   = 24,
    parameter int PIX  = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 frame_done,
    input logic [LOGN-1:0]      pat_idx,
    input logic [STW-1:0]       strip_idx,
    input logic                 res_valid,
    input logic                 res_ready,
    input logic [PXW-1:0]       res_pixel,
    input logic signed [OW-1:0] res_data,
    input logic                 done
);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_pixel)));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !frame_done) |=> done);

    p_done_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (done && frame_done) |=> !done);

    p_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !done);

    p_idx_step_r11: assert property (@(posedge clk) disable iff (rst)
        (pat_idx != '0) |-> (pat_idx == LOGN'($past(pat_idx) + 1'b1)));

    p_pix_step_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ready && (res_pixel != PXW'(PIX - 1)))
        |=> (!res_valid || (res_pixel == PXW'($past(res_pixel) + 1'b1))));

    p_strip_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (pat_idx == '0));

endmodule

bind scr_recon scr_recon_chk #(
    .LOGN (LOGN),
    .STW  (STW),
    .PXW  (PXW),
    .OW   (OW),
    .PIX  (PIX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .pat_idx    (pat_idx),
    .strip_idx  (strip_idx),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_pixel  (res_pixel),
    .res_data   (res_data),
    .done       (done)
);

// File: tb/sim_scr_recon.sv
module sim_scr_recon;
    import scr_pkg::*;

    localparam int NPAT  = DEF_NPAT;
    localparam int PIX   = DEF_PIX;
    localparam int LANES = DEF_LANES;
    localparam int SW    = DEF_SW;
    localparam int AW    = DEF_AW;
    localparam int ASQW  = DEF_ASQW;
    localparam int ACW   = DEF_ACW;
    localparam int BW    = DEF_BW;
    localparam int OW    = DEF_OW;
    localparam int LOGN  = idx_w(NPAT);
    localparam int STW   = idx_w(PIX / LANES);
    localparam int PXW   = STW + idx_w(LANES);
    localparam longint HI = (64'sd1 <<< (OW - 1)) - 1;
    localparam longint LO = -HI - 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 frame_done = 1'b0;
    logic [LOGN-1:0]      pat_idx;
    logic [STW-1:0]       strip_idx;
    logic [SW-1:0]        samp_q;
    logic [AW-1:0]        alpha_q;
    logic [ASQW-1:0]      asq_q;
    logic [LANES-1:0]     mask_q;
    logic [LANES*BW-1:0]  b_q;
    logic [ACW-1:0]       a_const = '0;
    logic                 res_valid;
    logic                 res_ready = 1'b1;
    logic [PXW-1:0]       res_pixel;
    logic signed [OW-1:0] res_data;
    logic                 done;

    int unsigned s_mem [NPAT];
    int unsigned a_mem [NPAT];
    int unsigned asq_mem [NPAT];
    bit          mk [NPAT][PIX];
    int unsigned b_mem [PIX];

    int     checks = 0;
    int     failures = 0;
    bit     bp_mode = 1'b0;
    bit     finished = 1'b0;
    int unsigned seed = 32'h1234_5678;
    int unsigned bp_lfsr = 32'hACE1;
    string  cur_tag = "R1";
    int     exp_pix [$];
    longint exp_val [$];

    always #10 clk = ~clk;

    scr_recon u0 (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .pat_idx    (pat_idx),
        .strip_idx  (strip_idx),
        .samp_data  (samp_q),
        .alpha      (alpha_q),
        .alpha_sq   (asq_q),
        .mask_bits  (mask_q),
        .b_coef     (b_q),
        .a_coef     (a_const),
        .res_valid  (res_valid),
        .res_ready  (res_ready),
        .res_pixel  (res_pixel),
        .res_data   (res_data),
        .done       (done)
    );

    // Table and buffer models: one-cycle registered reads
    always @(posedge clk) begin
        samp_q  <= SW'(s_mem[pat_idx]);
        alpha_q <= AW'(a_mem[pat_idx]);
        asq_q   <= ASQW'(asq_mem[pat_idx]);
        for (int l = 0; l < LANES; l++) begin
            mask_q[l]       <= mk[pat_idx][int'(strip_idx) * LANES + l];
            b_q[l*BW +: BW] <= BW'(b_mem[int'(strip_idx) * LANES + l]);
        end
    end

    function automatic int unsigned rnd(input int unsigned lim);
        seed = seed * 32'd1103515245 + 32'd12345;
        return (seed >> 8) % lim;
    endfunction

    task automatic check(input string tag, input bit ok, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push_expected();
        longint ms;
        ms = 0;
        for (int i = 0; i < NPAT; i++) ms += longint'(s_mem[i]) * longint'(a_mem[i]);
        ms = ms >>> LOGN;
        for (int p = 0; p < PIX; p++) begin
            longint c;
            longint o;
            c = 0;
            for (int i = 0; i < NPAT; i++)
                if (mk[i][p]) c += longint'(s_mem[i]) * longint'(asq_mem[i]);
            c = c >>> LOGN;
            o = longint'(a_const) * c - ms * longint'(b_mem[p]);
            if (o > HI) o = HI;
            if (o < LO) o = LO;
            exp_pix.push_back(p);
            exp_val.push_back(o);
        end
    endtask

    task automatic fill_small(input bit masks_on);
        for (int i = 0; i < NPAT; i++) begin
            s_mem[i]   = rnd(256);
            a_mem[i]   = rnd(16);
            asq_mem[i] = a_mem[i] * a_mem[i];
            for (int p = 0; p < PIX; p++) mk[i][p] = masks_on ? rnd(2) != 0 : 1'b0;
        end
        for (int p = 0; p < PIX; p++) b_mem[p] = rnd(1024);
        a_const = ACW'(rnd(64));
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 frame_done = 1'b1;
        @(posedge clk); #1 frame_done = 1'b0;
    endtask

    task automatic run_frame(input bit lat_check);
        push_expected();
        pulse_start();
        if (lat_check) begin
            // R6: start sampled at the edge just passed; first beat after N+1 edges
            repeat (NPAT) @(posedge clk);
            #1 check("R6 valid early", res_valid == 1'b0, res_valid, 0);
            check("R8 done clear while busy", done == 1'b0, done, 0);
            @(posedge clk);
            #1 check("R6 valid at N+1", res_valid == 1'b1, res_valid, 1);
        end
        wait (exp_pix.size() == 0);
        @(posedge clk);
        #1 check("R8 done after drain", done == 1'b1, done, 1);
    endtask

    // Host ready driver: changes just after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            bp_lfsr = {bp_lfsr[30:0], bp_lfsr[31] ^ bp_lfsr[21] ^ bp_lfsr[1] ^ bp_lfsr[0]};
            res_ready = bp_mode ? bp_lfsr[3] : 1'b1;
        end
    end

    // Monitor / scoreboard: samples on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && res_valid && res_ready) begin
                if (exp_pix.size() == 0) begin
                    check("R9 unexpected result", 1'b0, res_pixel, -1);
                end else begin
                    int     ep;
                    longint ev;
                    ep = exp_pix.pop_front();
                    ev = exp_val.pop_front();
                    check({"R5 pixel order ", cur_tag}, int'(res_pixel) == ep, res_pixel, ep);
                    check({cur_tag, " value"}, longint'(res_data) == ev, res_data, ev);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 1'b0, 0, 1);
        finish_run();
    end

    initial begin
        fill_small(1'b1);
        repeat (3) @(posedge clk);
        #1 check("R10 reset valid", res_valid == 1'b0, res_valid, 0);
        check("R10 reset done", done == 1'b0, done, 0);
        check("R11 reset index", pat_idx == '0, pat_idx, 0);
        rst = 1'b0;

        // Frame 1: general values, no saturation (R1, R3)
        cur_tag = "R1";
        run_frame(1'b1);

        // Frame 2: every mask bit zero (R2, R3)
        fill_small(1'b0);
        cur_tag = "R2";
        run_frame(1'b1);

        // Frame 3: both clamps (R4)
        for (int i = 0; i < NPAT; i++) begin
            s_mem[i]   = (1 << SW) - 1;
            a_mem[i]   = (1 << AW) - 1;
            asq_mem[i] = (1 << ASQW) - 1;
            for (int p = 0; p < PIX; p++) mk[i][p] = (p % 2) == 0;
        end
        for (int p = 0; p < PIX; p++) b_mem[p] = ((p % 2) == 0) ? 0 : (1 << BW) - 1;
        a_const = '1;
        cur_tag = "R4";
        run_frame(1'b0);

        // Frame 4: random backpressure and a start pulse while busy (R7, R9, R3)
        fill_small(1'b1);
        cur_tag = "R3";
        bp_mode = 1'b1;
        push_expected();
        pulse_start();
        repeat (NPAT + 6) @(posedge clk);
        #1 frame_done = 1'b1;
        @(posedge clk);
        #1 frame_done = 1'b0;
        wait (exp_pix.size() == 0);
        bp_mode = 1'b0;
        @(posedge clk);
        #1 check("R8 done after drain", done == 1'b1, done, 1);
        repeat (3 * NPAT) begin
            @(posedge clk);
            #1 check("R9 no restart", (res_valid == 1'b0) && (done == 1'b1), {res_valid, done}, 1);
        end

        // Frame 5: restart from done clears the flag next cycle (R8)
        fill_small(1'b1);
        cur_tag = "R1";
        push_expected();
        @(posedge clk); #1 frame_done = 1'b1;
        @(posedge clk); #1 frame_done = 1'b0;
        check("R8 done cleared by start", done == 1'b0, done, 0);
        wait (exp_pix.size() == 0);
        @(posedge clk);
        #1 check("R8 done after drain", done == 1'b1, done, 1);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule